// File: doc/BRIEF.md
# Machine cycle timing sequencer

This block divides a system clock into machine cycles of two lengths. A short cycle lasts four clock periods and a long cycle lasts six. A boundary strobe is high in the final period of each cycle and low in every other period. The next cycle's length is taken from a length request input. A 5-bit command code is taken from a command input. Both are sampled only in the strobe period, so each cycle carries exactly one command code, and that code is held unchanged from the first period of the cycle to the last.

The sequencer also owns the interrupt-enable flag. An enable command sets the flag. A disable command or an interrupt acknowledge clears it. These commands are taken only at a cycle boundary. While the chip-level reset is asserted the sequencer is idle: the strobe is low, the flag is cleared and the code is forced to the fetch-next-opcode value. When reset is released, the first cycle is a short fetch cycle. A free-running cycle counter steps at every boundary so that surrounding logic and benches can measure cycle lengths.

Top module: `mcyc_seq`

## Requirements
- R1: A cycle whose length bit is 0 lasts exactly SHORT_LEN (4) clock periods and a cycle whose length bit is 1 lasts exactly LONG_LEN (6) periods, counted from the period after one strobe up to and including the next strobe.
- R2: `cyc_end_o` is high in exactly one period per cycle, the last one, and is never high in two adjacent periods.
- R3: `len_long_i` and `next_code_i` are sampled only in a period where `cyc_end_o` is high and take effect from the first period of the following cycle. Their values in any other period have no effect.
- R4: `code_o` and `cyc_long_o` hold constant in every period of a cycle. `cyc_long_o` is 1 for a long cycle and 0 for a short one.
- R5: While `rst` (synchronous, active high) is sampled high, the next period shows `cyc_end_o`=0, `code_o`=0, `cyc_long_o`=0, `cyc_count_o`=0 and `ie_o`=0. Code value 0 means fetch the next opcode. The first cycle after release is short and carries code 0.
- R6: `ie_set_i` high in a strobe period, with `ie_clr_i` and `int_ack_i` low, makes `ie_o` 1 from the next period.
- R7: `ie_clr_i` or `int_ack_i` high in a strobe period makes `ie_o` 0 from the next period. This takes priority over `ie_set_i`.
- R8: `ie_set_i`, `ie_clr_i` and `int_ack_i` in a period where `cyc_end_o` is low leave `ie_o` unchanged.
- R9: `cyc_count_o` increases by one, modulo 2^CNT_W, in the period after each strobe and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, holds the sequencer idle |
| len_long_i | input | 1 | Length request for the next cycle (1 = long) |
| next_code_i | input | 5 | Command code for the next cycle |
| ie_set_i | input | 1 | Interrupt-enable set command |
| ie_clr_i | input | 1 | Interrupt-enable clear command |
| int_ack_i | input | 1 | Interrupt acknowledge, clears the enable |
| cyc_end_o | output | 1 | High in the final period of each cycle |
| cyc_long_o | output | 1 | Current cycle is long |
| code_o | output | 5 | Command code of the current cycle |
| cyc_count_o | output | CNT_W | Completed cycle count, wraps |
| ie_o | output | 1 | Interrupt enable |

## Verification
The assertions check the following in every period: the spacing between strobes against the current length bit, that the strobe is never high in adjacent periods, that code and length hold inside a cycle, the counter step, and the rule that the enable changes only at a boundary with clear winning over set. Some behaviour depends on which input value arrived in which period. Only the bench's scenarios show that: mid-cycle changes to the length and code requests are discarded, the first cycle after reset is short with the fetch code even when a long request is pending, and the counter wraps. The bench's behavioural model exposes these by comparing every output in every period.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int CODE_W = 5;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_FETCH = '0;

    typedef struct packed {
        logic  long_c;
        code_t code;
    } cyc_cmd_t;

    typedef enum logic [1:0] {
        IE_HOLD  = 2'd0,
        IE_SET   = 2'd1,
        IE_CLEAR = 2'd2
    } ie_op_t;

    function automatic ie_op_t ie_decode(input logic set, input logic clr, input logic ack);
        if (clr || ack) return IE_CLEAR;
        if (set)        return IE_SET;
        return IE_HOLD;
    endfunction

endpackage

// File: rtl/mcs_phase.sv
module mcs_phase #(
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic cur_long,
    output logic cyc_end
);
    localparam int PH_W = $clog2(LONG_LEN);
    localparam logic [PH_W-1:0] LAST_S = PH_W'(SHORT_LEN - 1);
    localparam logic [PH_W-1:0] LAST_L = PH_W'(LONG_LEN - 1);

    logic [PH_W-1:0] ph_q;

    assign cyc_end = (ph_q == (cur_long ? LAST_L : LAST_S));

    always_ff @(posedge clk) begin
        if (rst)          ph_q <= '0;
        else if (cyc_end) ph_q <= '0;
        else              ph_q <= ph_q + PH_W'(1);
    end
endmodule

// File: rtl/mcs_cmd_reg.sv
module mcs_cmd_reg import seq_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_end,
    input  cyc_cmd_t         nxt,
    output cyc_cmd_t         cur,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur.long_c <= 1'b0;
            cur.code   <= CODE_FETCH;
            count      <= '0;
        end else if (cyc_end) begin
            cur   <= nxt;
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mcs_ie.sv
module mcs_ie import seq_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic cyc_end,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic ack,
    output logic ie
);
    ie_op_t op;

    assign op = ie_decode(set_cmd, clr_cmd, ack);

    always_ff @(posedge clk) begin
        if (rst) ie <= 1'b0;
        else if (cyc_end) begin
            case (op)
                IE_SET:   ie <= 1'b1;
                IE_CLEAR: ie <= 1'b0;
                default:  ie <= ie;
            endcase
        end
    end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq import seq_pkg::*; #(
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 6,
    parameter int CNT_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  len_long_i,
    input  logic [CODE_W-1:0]     next_code_i,
    input  logic                  ie_set_i,
    input  logic                  ie_clr_i,
    input  logic                  int_ack_i,
    output logic                  cyc_end_o,
    output logic                  cyc_long_o,
    output logic [CODE_W-1:0]     code_o,
    output logic [CNT_W-1:0]      cyc_count_o,
    output logic                  ie_o
);
    cyc_cmd_t nxt_cmd;
    cyc_cmd_t cur_cmd;
    logic     cyc_end;

    assign nxt_cmd.long_c = len_long_i;
    assign nxt_cmd.code   = next_code_i;

    mcs_phase #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .cur_long (cur_cmd.long_c),
        .cyc_end  (cyc_end)
    );

    mcs_cmd_reg #(.CNT_W(CNT_W)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .cyc_end (cyc_end),
        .nxt     (nxt_cmd),
        .cur     (cur_cmd),
        .count   (cyc_count_o)
    );

    mcs_ie u_ie (
        .clk     (clk),
        .rst     (rst),
        .cyc_end (cyc_end),
        .set_cmd (ie_set_i),
        .clr_cmd (ie_clr_i),
        .ack     (int_ack_i),
        .ie      (ie_o)
    );

    assign cyc_end_o  = cyc_end;
    assign cyc_long_o = cur_cmd.long_c;
    assign code_o     = cur_cmd.code;
endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk import seq_pkg::*; #(
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 6,
    parameter int CNT_W     = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ie_set_i,
    input logic              ie_clr_i,
    input logic              int_ack_i,
    input logic              cyc_end_o,
    input logic              cyc_long_o,
    input logic [CODE_W-1:0] code_o,
    input logic [CNT_W-1:0]  cyc_count_o,
    input logic              ie_o
);
    int unsigned gap;

    always_ff @(posedge clk) begin
        if (rst || cyc_end_o) gap <= 1;
        else                  gap <= gap + 1;
    end

    assert_cycle_len_R1: assert property (@(posedge clk) disable iff (rst)
        cyc_end_o |-> gap == (cyc_long_o ? 32'(LONG_LEN) : 32'(SHORT_LEN)));

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        cyc_end_o |=> !cyc_end_o);

    assert_code_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cyc_end_o |=> ($stable(code_o) && $stable(cyc_long_o)));

    assert_reset_idle_R5: assert property (@(posedge clk)
        rst |=> (!cyc_end_o && code_o == CODE_FETCH && !cyc_long_o && cyc_count_o == '0 && !ie_o));

    assert_ie_set_R6: assert property (@(posedge clk) disable iff (rst)
        (cyc_end_o && ie_set_i && !ie_clr_i && !int_ack_i) |=> ie_o);

    assert_ie_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (cyc_end_o && (ie_clr_i || int_ack_i)) |=> !ie_o);

    assert_ie_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cyc_end_o |=> $stable(ie_o));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        cyc_end_o |=> cyc_count_o == $past(cyc_count_o) + CNT_W'(1));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cyc_end_o |=> $stable(cyc_count_o));
endmodule

bind mcyc_seq mcyc_seq_chk #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ie_set_i    (ie_set_i),
    .ie_clr_i    (ie_clr_i),
    .int_ack_i   (int_ack_i),
    .cyc_end_o   (cyc_end_o),
    .cyc_long_o  (cyc_long_o),
    .code_o      (code_o),
    .cyc_count_o (cyc_count_o),
    .ie_o        (ie_o)
);

// File: tb/tb_mcyc_seq.sv
`timescale 1ns/1ps
module tb_mcyc_seq;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          len_long_i = 1'b0;
    logic [4:0]    next_code_i = '0;
    logic          ie_set_i = 1'b0;
    logic          ie_clr_i = 1'b0;
    logic          int_ack_i = 1'b0;
    logic          cyc_end_o, cyc_long_o, ie_o;
    logic [4:0]    code_o;
    logic [CW-1:0] cyc_count_o;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // reference model state: periods left after the current one
    int m_rem = 3, m_long = 0, m_code = 0, m_cnt = 0, m_ie = 0;

    always #5 clk = ~clk;

    mcyc_seq #(.SHORT_LEN(4), .LONG_LEN(6), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .len_long_i(len_long_i), .next_code_i(next_code_i),
        .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .int_ack_i(int_ack_i),
        .cyc_end_o(cyc_end_o), .cyc_long_o(cyc_long_o), .code_o(code_o),
        .cyc_count_o(cyc_count_o), .ie_o(ie_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_rem = 3; m_long = 0; m_code = 0; m_cnt = 0; m_ie = 0;
        end else if (m_rem == 0) begin
            m_long = int'(len_long_i);
            m_rem  = m_long ? 5 : 3;
            m_code = int'(next_code_i);
            m_cnt  = (m_cnt + 1) % (1 << CW);
            if (ie_clr_i || int_ack_i) m_ie = 0;
            else if (ie_set_i)         m_ie = 1;
        end else begin
            m_rem = m_rem - 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare every output against the model in the current period
    task automatic cmp_all();
        chk("R2 strobe",   int'(cyc_end_o),   int'(m_rem == 0));
        chk("R4 length",   int'(cyc_long_o),  m_long);
        chk("R4 code",     int'(code_o),      m_code);
        chk("R9 count",    int'(cyc_count_o), m_cnt);
        chk("R6/R7 ie",    int'(ie_o),        m_ie);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic to_strobe();
        for (int k = 0; k < 8 && !cyc_end_o; k++) step();
    endtask

    task automatic idle_inputs();
        len_long_i = 0; next_code_i = 0; ie_set_i = 0; ie_clr_i = 0; int_ack_i = 0;
    endtask

    initial begin
        int gapn;
        @(negedge clk);
        for (int i = 0; i < 4; i++) step();
        // R5: idle while reset held
        chk("R5 reset strobe", int'(cyc_end_o), 0);
        chk("R5 reset ie", int'(ie_o), 0);
        chk("R5 reset code", int'(code_o), 0);

        // release; pending long request and code 7 are ignored mid-cycle (R3)
        rst = 0;
        len_long_i = 1; next_code_i = 5'd7; ie_set_i = 1;
        gapn = 1;
        while (!cyc_end_o && gapn < 10) begin step(); gapn++; end
        chk("R1 R5 first cycle short", gapn, 4);
        chk("R5 first code fetch", int'(code_o), 0);
        len_long_i = 0; next_code_i = 5'd9; ie_set_i = 0;
        step();
        chk("R3 code from strobe period", int'(code_o), 9);
        chk("R8 ie set outside strobe ignored", int'(ie_o), 0);

        // long cycle length (R1)
        to_strobe();
        len_long_i = 1; next_code_i = 5'd21; ie_set_i = 1;
        step();
        idle_inputs();
        gapn = 1;
        while (!cyc_end_o && gapn < 10) begin step(); gapn++; end
        chk("R1 long cycle", gapn, 6);
        chk("R6 ie set at strobe", int'(ie_o), 1);
        chk("R4 long code held", int'(code_o), 21);

        // clear wins over set (R7); mid-cycle clear ignored (R8)
        ie_clr_i = 0; ie_set_i = 0;
        step();
        int_ack_i = 1;
        step();
        chk("R8 ack outside strobe ignored", int'(ie_o), 1);
        int_ack_i = 0;
        to_strobe();
        ie_set_i = 1; ie_clr_i = 1;
        step();
        chk("R7 clear beats set", int'(ie_o), 0);
        idle_inputs();

        // random traffic with inputs changing every period (R3, R8, R9 wrap)
        for (int n = 0; n < 3000; n++) begin
            len_long_i  = ($urandom % 3) == 0;
            next_code_i = 5'($urandom);
            ie_set_i    = ($urandom % 4) == 0;
            ie_clr_i    = ($urandom % 9) == 0;
            int_ack_i   = ($urandom % 11) == 0;
            rst         = (n == 1500) || (n == 1501);
            step();
        end
        rst = 0;
        idle_inputs();
        step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule